// File: doc/BRIEF.md
# NAND Flash Command-Cycle Sequencer

This block runs one complete NAND flash transaction on its own once software has programmed it. Software fills in up to three opcode bytes, a 16-bit column address, a 24-bit row address, a byte count and a 16-bit phase code, and then sets a start bit. Each bit of the phase code turns one phase on. Enabled phases always run in the same hardware order and clear bits are skipped. A phase can be a command latch, an address byte, a data burst to or from a page buffer, a wait on ready/busy, or a status or ID read.

Every bus cycle drives WE# or RE# low for a programmable number of clocks and then high again. CLE, ALE and the data lines stay stable for the whole cycle. Page data moves through a 32-bit word port to an external buffer RAM. Inside each word the bytes are big-endian: the first flash byte goes to the top lane. When the last phase completes, an idle flag rises. The flag can raise an interrupt, which software can enable and clear.

Top module: `nand_seq`

## Requirements
- R1: After reset, every CE# line, WE#, RE# and `irq` are high-inactive or low as appropriate (CE#, WE#, RE# high; `irq` low), and the flag register (address 6) and the command register (address 1) read 0.
- R2: Phase-code bits run from bit 14 down to bit 2. Clear bits are skipped, and bits 15, 1 and 0 have no effect. Bit 14 latches opcode A (register 1, bits 31:24), bit 7 latches opcode B (register 0, bits 31:24) and bit 4 latches opcode C (register 0, bits 23:16). Each latch is one WE# cycle with CLE high.
- R3: Bits 13 to 9 each send one WE# cycle with ALE high. In order, they send column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8 and row bits 23:16. The column is register 2 and the row is register 3.
- R4: The read-data phase (bit 5) stores byte k of the transfer into buffer word k/4, bits [31-8*(k%4) -: 8]. The byte count comes from register 4. `buf_sel` shows register 1 bits 2:1.
- R5: The write-data phase (bit 8) sends the byte count's worth of bytes from the buffer, using the same byte ordering, on WE# cycles with CLE and ALE low.
- R6: When configuration bit 7 (register 5) is set, each data cycle carries two bytes, with the earlier byte on io[7:0]. Opcode and address cycles always use io[7:0] with io[15:8] at zero.
- R7: WE# and RE# stay low for SETUP clocks and then high for at least HOLD clocks before the next cycle. SETUP is register 5 bits 11:8 and HOLD is bits 15:12. A zero value in either field means 1.
- R8: The handshake phase (bit 6) watches the R/B# lines selected by register 3 bits 31:28. It starts no bus cycle until the selected lines have been seen low and then all high again.
- R9: If the handshake does not complete within TMO_CYC clocks, the timeout flag (register 6 bit 28) sets and the transaction carries on.
- R10: Reply register 7 is cleared at start. Each status byte (bit 3, one RE# cycle) and each ID byte (bit 2, four RE# cycles) shifts into it from the low end.
- R11: The idle flag (register 6 bit 29) is low from start until the last phase ends, then it sets together with the done flag (bit 30). Writing 1 to bit 17 clears idle and writing 1 to bit 18 clears done. `irq` is the idle flag gated by the enable in bit 20.
- R12: Writes to registers 0 to 5 while a transaction runs are ignored, including a new start. The start bit always reads 0.
- R13: CE# outputs the inverse of register 3 bits 27:24 while a transaction runs and stays all high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Idle interrupt |
| buf_sel | output | 2 | Selected page buffer number |
| buf_addr | output | LEN_W-2 | Buffer word address |
| buf_we | output | 1 | Buffer write strobe |
| buf_be | output | 4 | Buffer byte-lane enables, bit 3 = top lane |
| buf_wdata | output | 32 | Buffer write data |
| buf_rdata | input | 32 | Buffer read data, one clock after address |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 16 | Flash data bus, driven value |
| nand_io_oe | output | 1 | Flash data bus output enable |
| nand_io_in | input | 16 | Flash data bus, received value |
| nand_rb_n | input | 4 | Ready/busy lines, low = busy |

## Verification
Register reads are combinational, so the bench samples them on the same falling edge at which it presents the address. The idle and done flags rise one clock after the last phase has retired, and the bench polls for them rather than predicting the exact edge. The bench's flash model watches WE# and RE# on every falling edge. It measures each low pulse and each high gap against the programmed SETUP and HOLD values, and it logs CLE, ALE and io at each WE# rise. The model returns read data on each RE# fall, which is at least one edge before the design captures it at the end of the low time. Buffer contents, the reply register and the logged cycle sequence are compared only after the idle flag is seen.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

    // Phase numbers equal the bit position in the phase code; higher runs first.
    localparam logic [3:0] PH_OPA  = 4'd14;
    localparam logic [3:0] PH_COL0 = 4'd13;
    localparam logic [3:0] PH_COL1 = 4'd12;
    localparam logic [3:0] PH_ROW0 = 4'd11;
    localparam logic [3:0] PH_ROW1 = 4'd10;
    localparam logic [3:0] PH_ROW2 = 4'd9;
    localparam logic [3:0] PH_WR   = 4'd8;
    localparam logic [3:0] PH_OPB  = 4'd7;
    localparam logic [3:0] PH_RB   = 4'd6;
    localparam logic [3:0] PH_RD   = 4'd5;
    localparam logic [3:0] PH_OPC  = 4'd4;
    localparam logic [3:0] PH_STAT = 4'd3;
    localparam logic [3:0] PH_ID   = 4'd2;
    localparam logic [15:0] PH_VALID = 16'h7FFC;
endpackage

// File: rtl/nand_seq_pick.sv
module nand_seq_pick #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (mask[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] setup,
    input  logic [CW-1:0] hold,
    output logic          busy,
    output logic          strobe_low,
    output logic          sample,
    output logic          done
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          busy;
        logic          low;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        sample = 1'b0;
        done   = 1'b0;
        if (!s_q.busy) begin
            if (go) begin
                s_d.busy = 1'b1;
                s_d.low  = 1'b1;
                s_d.cnt  = setup - ONE;
            end
        end else if (s_q.low) begin
            if (s_q.cnt == '0) begin
                sample  = 1'b1;
                s_d.low = 1'b0;
                s_d.cnt = hold - ONE;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end else begin
            if (s_q.cnt == '0) begin
                done     = 1'b1;
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign strobe_low = s_q.busy & s_q.low;

    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !s_q.busy); // R7
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int TMO_CYC = 1024,
    localparam int ABW    = LEN_W - 2,
    localparam int TW     = $clog2(TMO_CYC) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic [1:0]       buf_sel,
    output logic [ABW-1:0]   buf_addr,
    output logic             buf_we,
    output logic [3:0]       buf_be,
    output logic [31:0]      buf_wdata,
    input  logic [31:0]      buf_rdata,
    output logic [3:0]       nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [15:0]      nand_io_out,
    output logic             nand_io_oe,
    input  logic [15:0]      nand_io_in,
    input  logic [3:0]       nand_rb_n
);
    localparam int CW = 4;

    typedef struct packed {
        seq_st_e          st;
        logic [15:0]      opbc;
        logic [7:0]       opa;
        logic [15:0]      code;
        logic [1:0]       bsel;
        logic [15:0]      col;
        logic [31:0]      row;
        logic [LEN_W-1:0] len;
        logic [15:0]      cfg;
        logic             idle;
        logic             done;
        logic             tmo;
        logic             ien;
        logic [15:0]      rem;
        logic [LEN_W-1:0] cnt;
        logic             seen_lo;
        logic [TW-1:0]    tcnt;
        logic [31:0]      reply;
    } seq_t;

    seq_t s_d, s_q;

    logic [3:0]       ph;
    logic             any, running, wide, is_rb, is_cmd, is_adr, is_wr, is_rd;
    logic             go, t_busy, t_low, t_sample, t_done, rb_ok;
    logic [CW-1:0]    setup, hold;
    logic [LEN_W-1:0] ncyc, bidx;
    logic [31:0]      shifted;

    nand_seq_pick #(.W(16)) u_pick (.mask(s_q.rem), .idx(ph), .any(any));

    nand_seq_strobe #(.CW(CW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(go), .setup(setup), .hold(hold),
        .busy(t_busy), .strobe_low(t_low), .sample(t_sample), .done(t_done));

    always_comb begin
        s_d     = s_q;
        running = (s_q.st == ST_RUN);
        wide    = s_q.cfg[7];
        setup   = (s_q.cfg[11:8] == '0) ? CW'(1) : s_q.cfg[11:8];
        hold    = (s_q.cfg[15:12] == '0) ? CW'(1) : s_q.cfg[15:12];
        is_rb   = (ph == PH_RB);
        is_cmd  = (ph == PH_OPA) || (ph == PH_OPB) || (ph == PH_OPC);
        is_adr  = (ph <= PH_COL0) && (ph >= PH_ROW2);
        is_wr   = (ph == PH_WR);
        is_rd   = (ph == PH_RD) || (ph == PH_STAT) || (ph == PH_ID);
        case (ph)
            PH_WR, PH_RD: ncyc = wide ? (s_q.len >> 1) : s_q.len;
            PH_ID:        ncyc = LEN_W'(4);
            default:      ncyc = LEN_W'(1);
        endcase
        go      = running && any && !is_rb && (ncyc != '0) && !t_busy;
        rb_ok   = &(nand_rb_n | ~s_q.row[31:28]);
        bidx    = wide ? {s_q.cnt[LEN_W-2:0], 1'b0} : s_q.cnt;
        shifted = buf_rdata << {bidx[1:0], 3'b000};

        // Pin and buffer drive
        buf_addr  = bidx[LEN_W-1:2];
        buf_sel   = s_q.bsel;
        buf_we    = t_sample && (ph == PH_RD);
        buf_be    = wide ? (4'b1100 >> bidx[1:0]) : (4'b1000 >> bidx[1:0]);
        buf_wdata = wide ? {2{nand_io_in[7:0], nand_io_in[15:8]}} : {4{nand_io_in[7:0]}};
        case (ph)
            PH_OPA:  nand_io_out = {8'h00, s_q.opa};
            PH_OPB:  nand_io_out = {8'h00, s_q.opbc[15:8]};
            PH_OPC:  nand_io_out = {8'h00, s_q.opbc[7:0]};
            PH_COL0: nand_io_out = {8'h00, s_q.col[7:0]};
            PH_COL1: nand_io_out = {8'h00, s_q.col[15:8]};
            PH_ROW0: nand_io_out = {8'h00, s_q.row[7:0]};
            PH_ROW1: nand_io_out = {8'h00, s_q.row[15:8]};
            PH_ROW2: nand_io_out = {8'h00, s_q.row[23:16]};
            default: nand_io_out = wide ? {shifted[23:16], shifted[31:24]} : {8'h00, shifted[31:24]};
        endcase
        nand_io_oe = t_busy && (is_cmd || is_adr || is_wr);
        nand_cle   = t_busy && is_cmd;
        nand_ale   = t_busy && is_adr;
        nand_we_n  = !(t_low && (is_cmd || is_adr || is_wr));
        nand_re_n  = !(t_low && is_rd);
        nand_ce_n  = running ? ~s_q.row[27:24] : 4'hF;
        irq        = s_q.idle && s_q.ien;

        // Register writes
        if (reg_wr) begin
            case (reg_addr)
                3'd0: if (!running) s_d.opbc = reg_wdata[31:16];
                3'd1: if (!running) begin
                    s_d.opa  = reg_wdata[31:24];
                    s_d.code = reg_wdata[23:8];
                    s_d.bsel = reg_wdata[2:1];
                    if (reg_wdata[0]) begin
                        s_d.st      = ST_RUN;
                        s_d.rem     = reg_wdata[23:8] & PH_VALID;
                        s_d.idle    = 1'b0;
                        s_d.tmo     = 1'b0;
                        s_d.reply   = '0;
                        s_d.cnt     = '0;
                        s_d.tcnt    = '0;
                        s_d.seen_lo = 1'b0;
                    end
                end
                3'd2: if (!running) s_d.col = reg_wdata[15:0];
                3'd3: if (!running) s_d.row = reg_wdata;
                3'd4: if (!running) s_d.len = reg_wdata[LEN_W-1:0];
                3'd5: if (!running) s_d.cfg = reg_wdata[15:0];
                3'd6: begin
                    s_d.ien = reg_wdata[20];
                    if (reg_wdata[18]) s_d.done = 1'b0;
                    if (reg_wdata[17]) s_d.idle = 1'b0;
                end
                default: ;
            endcase
        end

        // Phase engine
        if (running) begin
            if (!any) begin
                s_d.st   = ST_IDLE;
                s_d.idle = 1'b1;
                s_d.done = 1'b1;
            end else if (is_rb) begin
                s_d.tcnt = s_q.tcnt + TW'(1);
                if (!rb_ok) s_d.seen_lo = 1'b1;
                if ((s_q.seen_lo && rb_ok) || (s_q.tcnt == TW'(TMO_CYC - 1))) begin
                    if (!(s_q.seen_lo && rb_ok)) s_d.tmo = 1'b1;
                    s_d.rem[ph] = 1'b0;
                    s_d.tcnt    = '0;
                    s_d.seen_lo = 1'b0;
                end
            end else if (ncyc == '0) begin
                s_d.rem[ph] = 1'b0;
            end else begin
                if (t_sample && ((ph == PH_STAT) || (ph == PH_ID)))
                    s_d.reply = {s_q.reply[23:0], nand_io_in[7:0]};
                if (t_done) begin
                    if (s_q.cnt + LEN_W'(1) == ncyc) begin
                        s_d.rem[ph] = 1'b0;
                        s_d.cnt     = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + LEN_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = {s_q.opbc, 16'h0000};
            3'd1:    reg_rdata = {s_q.opa, s_q.code, 5'b0, s_q.bsel, 1'b0};
            3'd2:    reg_rdata = {16'h0000, s_q.col};
            3'd3:    reg_rdata = s_q.row;
            3'd4:    reg_rdata = 32'(s_q.len);
            3'd5:    reg_rdata = {16'h0000, s_q.cfg};
            3'd6:    reg_rdata = {1'b0, s_q.done, s_q.idle, s_q.tmo, 7'b0, s_q.ien, 20'h0};
            default: reg_rdata = s_q.reply;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        nand_we_n || nand_re_n); // R7
    AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ((s_q.rem & ~$past(s_q.rem)) == 16'h0)); // R12
    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !any) |=> s_q.idle); // R11
    AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !s_q.idle); // R11
    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        nand_io_oe |-> nand_re_n); // R5
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  buf_sel;
    logic [9:0]  buf_addr;
    logic        buf_we;
    logic [3:0]  buf_be;
    logic [31:0] buf_wdata;
    logic [31:0] buf_rdata;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [15:0] nand_io_out;
    logic [15:0] nand_io_in = '0;
    logic [3:0]  nand_rb_n = 4'hF;

    int checks = 0, errors = 0, cyc = 0;
    int exp_setup = 1, exp_hold = 1;
    logic [3:0] exp_ce = 4'hE;
    logic [31:0] mem [0:63];
    logic [17:0] ev_q[$];
    logic [17:0] exp_q[$];
    logic [15:0] rd_q[$];
    int we_lo = 0, re_lo = 0, hi_gap = 100;
    logic we_prev = 1'b1, re_prev = 1'b1;
    int rb_rise_cyc = 0, first_re_cyc = -1;

    always #10 clk = ~clk;

    nand_seq #(.LEN_W(12), .TMO_CYC(TMO)) u_nand_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .buf_sel(buf_sel),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_be(buf_be), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
        .nand_rb_n(nand_rb_n));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Buffer RAM: synchronous read, byte-lane writes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (buf_we)
            for (int l = 0; l < 4; l++)
                if (buf_be[l]) mem[buf_addr[5:0]][8*l +: 8] <= buf_wdata[8*l +: 8];
        buf_rdata <= mem[buf_addr[5:0]];
    end

    // Flash model and per-clock pin checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n || !nand_re_n) chk("R13 CE# during cycle", {28'h0, nand_ce_n}, {28'h0, exp_ce});
            if ((!nand_we_n && we_prev) || (!nand_re_n && re_prev))
                chk("R7 high gap >= HOLD", {31'h0, hi_gap >= exp_hold}, 32'h1);
            if (!nand_re_n && re_prev) begin
                if (rd_q.size() > 0) nand_io_in = rd_q.pop_front();
                if (first_re_cyc < 0) first_re_cyc = cyc;
            end
            if (nand_we_n && !we_prev) begin
                ev_q.push_back({nand_cle, nand_ale, nand_io_out});
                chk("R7 WE# low width", we_lo, exp_setup);
                we_lo = 0;
            end
            if (nand_re_n && !re_prev) begin
                chk("R7 RE# low width", re_lo, exp_setup);
                re_lo = 0;
            end
            if (!nand_we_n) we_lo++;
            if (!nand_re_n) re_lo++;
            if (nand_we_n && nand_re_n) hi_gap++; else hi_gap = 0;
            we_prev = nand_we_n;
            re_prev = nand_re_n;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start(input logic [7:0] opa, input logic [15:0] code, input logic [1:0] bs);
        wr(3'd1, {opa, code, 5'b0, bs, 1'b1});
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd6, v);
            if (v[29]) return;
        end
        chk("watch idle", 32'h0, 32'h1);
    endtask

    task automatic expect_ev(input logic cle, input logic ale, input logic [15:0] io);
        exp_q.push_back({cle, ale, io});
    endtask

    task automatic cmp_ev(input string tag);
        chk({tag, " cycle count"}, ev_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < ev_q.size(); i++)
            chk(tag, {14'h0, ev_q[i]}, {14'h0, exp_q[i]});
        ev_q.delete();
        exp_q.delete();
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 CE#", {28'h0, nand_ce_n}, 32'hF);
        chk("R1 WE#/RE#", {30'h0, nand_we_n, nand_re_n}, 32'h3);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(3'd6, v); chk("R1 flags", v, 32'h0);
        rd(3'd1, v); chk("R1 command reg", v, 32'h0);

        // R3 R4 R8 R11: read page with address, handshake, 8-bit data
        wr(3'd5, 32'h0000_1200); exp_setup = 2; exp_hold = 1;
        wr(3'd0, 32'h3000_0000);
        wr(3'd2, 32'h0000_0201);
        wr(3'd3, 32'h1110_5432);
        wr(3'd4, 32'd6);
        wr(3'd6, 32'h0010_0000);
        for (int i = 0; i < 6; i++) rd_q.push_back(16'h00A1 + 16'(i));
        first_re_cyc = -1;
        fork
            begin
                wait (ev_q.size() == 7);
                repeat (4) @(negedge clk);
                nand_rb_n[0] = 1'b0;
                repeat (6) @(negedge clk);
                nand_rb_n[0] = 1'b1;
                rb_rise_cyc = cyc;
            end
        join_none
        start(8'h00, 16'h7EE0, 2'd2);
        rd(3'd6, v); chk("R11 idle low after start", {31'h0, v[29]}, 32'h0);
        chk("R4 buf_sel", {30'h0, buf_sel}, 32'h2);
        wait_idle();
        expect_ev(1, 0, 16'h0000);
        expect_ev(0, 1, 16'h0001); expect_ev(0, 1, 16'h0002);
        expect_ev(0, 1, 16'h0032); expect_ev(0, 1, 16'h0054); expect_ev(0, 1, 16'h0010);
        expect_ev(1, 0, 16'h0030);
        cmp_ev("R3 address/opcode cycles");
        chk("R8 no read before R/B# high", {31'h0, first_re_cyc > rb_rise_cyc}, 32'h1);
        chk("R4 word0", mem[0], 32'hA1A2A3A4);
        chk("R4 word1", mem[1], 32'hA5A60000);
        rd(3'd6, v); chk("R11 done+idle set", {30'h0, v[30], v[29]}, 32'h3);
        chk("R11 irq raised", {31'h0, irq}, 32'h1);
        wr(3'd6, 32'h0016_0000);
        rd(3'd6, v); chk("R11 W1C clears", {30'h0, v[30], v[29]}, 32'h0);
        chk("R11 irq cleared", {31'h0, irq}, 32'h0);

        // R5 write data from buffer
        wr(3'd5, 32'h0000_2300); exp_setup = 3; exp_hold = 2;
        wr(3'd0, 32'h1000_0000);
        wr(3'd4, 32'd5);
        mem[0] = 32'hC0C1C2C3; mem[1] = 32'hC4000000;
        start(8'h80, 16'h7180, 2'd0);
        wait_idle();
        expect_ev(1, 0, 16'h0080);
        expect_ev(0, 1, 16'h0001); expect_ev(0, 1, 16'h0002);
        for (int i = 0; i < 5; i++) expect_ev(0, 0, 16'h00C0 + 16'(i));
        expect_ev(1, 0, 16'h0010);
        cmp_ev("R5 write cycles");

        // R10 status then ID
        rd_q.push_back(16'h00E0);
        start(8'h70, 16'h4008, 2'd0);
        wait_idle();
        rd(3'd7, v); chk("R10 status reply", v, 32'h0000_00E0);
        expect_ev(1, 0, 16'h0070); cmp_ev("R10 status opcode");
        rd_q.push_back(16'h002C); rd_q.push_back(16'h00DA);
        rd_q.push_back(16'h0010); rd_q.push_back(16'h0095);
        start(8'h90, 16'h6004, 2'd0);
        wait_idle();
        rd(3'd7, v); chk("R10 ID reply", v, 32'h2CDA_1095);
        expect_ev(1, 0, 16'h0090); expect_ev(0, 1, 16'h0001); cmp_ev("R10 ID cycles");

        // R6 16-bit bus
        wr(3'd5, 32'h0000_1180); exp_setup = 1; exp_hold = 1;
        wr(3'd4, 32'd4);
        rd_q.push_back(16'h2211); rd_q.push_back(16'h4433);
        mem[0] = 32'h0;
        start(8'h05, 16'h4020, 2'd0);
        wait_idle();
        chk("R6 wide read word", mem[0], 32'h11223344);
        expect_ev(1, 0, 16'h0005); cmp_ev("R6 opcode on low byte");

        // R2 fixed order, stray bits ignored, zero SETUP/HOLD read as 1
        wr(3'd5, 32'h0000_0000);
        wr(3'd0, 32'hB2B3_0000);
        start(8'hB1, 16'hC093, 2'd0);
        wait_idle();
        expect_ev(1, 0, 16'h00B1); expect_ev(1, 0, 16'h00B2); expect_ev(1, 0, 16'h00B3);
        cmp_ev("R2 phase order");

        // R12 start while running is ignored
        start(8'hAA, 16'h4040, 2'd0);
        wait (ev_q.size() == 1);
        wr(3'd1, {8'h55, 16'h4000, 8'h01});
        rd(3'd1, v);
        chk("R12 opcode kept", {24'h0, v[31:24]}, 32'hAA);
        chk("R12 start reads 0", {31'h0, v[0]}, 32'h0);
        nand_rb_n[0] = 1'b0;
        repeat (3) @(negedge clk);
        nand_rb_n[0] = 1'b1;
        wait_idle();
        expect_ev(1, 0, 16'h00AA); cmp_ev("R12 only first transaction");

        // R9 timeout, R11 masked interrupt
        wr(3'd6, 32'h0006_0000);
        start(8'h00, 16'h0040, 2'd0);
        wait_idle();
        rd(3'd6, v); chk("R9 timeout flag", {31'h0, v[28]}, 32'h1);
        chk("R11 irq masked", {31'h0, irq}, 32'h0);
        rd(3'd6, v); chk("R13 CE# high when idle", {28'h0, nand_ce_n}, 32'hF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule